// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

This block is a small single-accumulator processor. It works on 16-bit words. Every instruction carries a 4-bit operation code in its upper bits and a 12-bit direct word address in its lower bits. A sequencer steps each instruction through a fetch phase and an execute phase. The program counter, instruction register, memory address register, memory buffer register and accumulator are explicit registers. Every access to the internal word memory uses the address register for the location and the buffer register for the data.

The core can load the accumulator from memory, add a memory word to the accumulator, and store the accumulator to memory. Any other operation code stops it for good, until the next reset. The memory has a preload write port. A host uses that port to place the program and the data while it holds the core in reset. It then releases reset and watches the halted flag and the debug outputs. Memory contents persist across resets, so a later program can read back what an earlier one stored.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is asserted, `dbg_pc` equals the `START_PC` parameter (default 0x300), and `dbg_ac`, `dbg_ir` and `halted` are all zero.
- R2: Fetch reads the word at the program counter into the instruction register and raises the program counter by exactly one. The count wraps within 12 bits. After release, `dbg_pc` shows start+1 after the second rising edge, and `dbg_ir` shows the first word after the third.
- R3: Operation code 0x1 (bits 15:12) replaces the accumulator with the memory word whose address is in bits 11:0. The accumulator changes at no other step than an instruction's final write-back cycle.
- R4: Operation code 0x5 adds the addressed memory word to the accumulator modulo 2^16, and the carry is discarded.
- R5: Operation code 0x2 writes the accumulator to the addressed word. The written value equals the accumulator, and a later load of that word returns it.
- R6: Any operation code other than 0x1, 0x2 or 0x5 asserts `halted`. From then until reset, `halted` stays high and `dbg_pc`, `dbg_ac` and `dbg_ir` do not change. The halting word is left in `dbg_ir`.
- R7: Preload writes (`pre_wr_en`, `pre_wr_addr`, `pre_wr_data`) take effect only while `rst_n` is low. They are ignored while the core runs, and the core never writes memory during reset.
- R8: Load and add take six clock cycles each, and store takes five. A halting word raises `halted` on the fourth cycle of its fetch. The program load, add, store, halt therefore shows `halted` first after the twentieth rising edge following release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; also enables preloading |
| pre_wr_en | input | 1 | Preload write strobe, honoured only in reset |
| pre_wr_addr | input | 12 | Preload word address |
| pre_wr_data | input | 16 | Preload word |
| halted | output | 1 | Core has met a non-executable operation code |
| dbg_pc | output | 12 | Program counter |
| dbg_ac | output | 16 | Accumulator |
| dbg_ir | output | 16 | Instruction register |

## Verification
The preload port and the core's own store can be active in the same cycle, because the host may leave its strobe raised while the program runs. The bench holds `pre_wr_en` high, with a conflicting value aimed at the very word the program stores to, for the whole first run. A second run after reset loads that word back into the accumulator. The run passes only if the accumulator shows the stored sum and not the preload value. The same runs also check the overflow behaviour of the add and the exact cycle count at which `halted` rises.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OP_W = 4;

   localparam logic [OP_W-1:0] OPC_LOAD  = 4'h1;
   localparam logic [OP_W-1:0] OPC_STORE = 4'h2;
   localparam logic [OP_W-1:0] OPC_ADD   = 4'h5;

   typedef enum logic [2:0] {
      SQ_FETCH_ADDR,
      SQ_FETCH_READ,
      SQ_DECODE,
      SQ_EXEC_ADDR,
      SQ_EXEC_MEM,
      SQ_EXEC_WB,
      SQ_HALT
   } seq_state_e;

   typedef struct packed {
      logic mar_pc;
      logic mar_ir;
      logic mbr_mem;
      logic mbr_ac;
      logic ir_ld;
      logic pc_inc;
      logic ac_ld;
      logic ac_add;
      logic mem_wr;
   } ctl_t;

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 12,
   parameter int WORDS  = 4096
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] rd_word
);

   logic [WORD_W-1:0] cells_q [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) cells_q[addr] <= wr_data;
   end

   // captured only by the buffer register, which forms the read latency
   assign rd_word = cells_q[addr];

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
   import acc_cpu_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] mbr_op,
   input  logic [OP_W-1:0] ir_op,
   output ctl_t            ctl,
   output seq_state_e      state,
   output logic            halted
);

   seq_state_e state_q, state_d;
   logic       op_known;

   assign op_known = (mbr_op == OPC_LOAD) || (mbr_op == OPC_STORE) || (mbr_op == OPC_ADD);

   always_comb begin
      ctl     = '0;
      state_d = state_q;
      unique case (state_q)
         SQ_FETCH_ADDR: begin
            ctl.mar_pc = 1'b1;
            state_d    = SQ_FETCH_READ;
         end
         SQ_FETCH_READ: begin
            ctl.mbr_mem = 1'b1;
            ctl.pc_inc  = 1'b1;
            state_d     = SQ_DECODE;
         end
         SQ_DECODE: begin
            ctl.ir_ld = 1'b1;
            state_d   = op_known ? SQ_EXEC_ADDR : SQ_HALT;
         end
         SQ_EXEC_ADDR: begin
            ctl.mar_ir = 1'b1;
            ctl.mbr_ac = (ir_op == OPC_STORE);
            state_d    = SQ_EXEC_MEM;
         end
         SQ_EXEC_MEM: begin
            if (ir_op == OPC_STORE) begin
               ctl.mem_wr = 1'b1;
               state_d    = SQ_FETCH_ADDR;
            end else begin
               ctl.mbr_mem = 1'b1;
               state_d     = SQ_EXEC_WB;
            end
         end
         SQ_EXEC_WB: begin
            ctl.ac_ld  = (ir_op == OPC_LOAD);
            ctl.ac_add = (ir_op == OPC_ADD);
            state_d    = SQ_FETCH_ADDR;
         end
         default: state_d = SQ_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SQ_FETCH_ADDR;
      else        state_q <= state_d;
   end

   assign state  = state_q;
   assign halted = (state_q == SQ_HALT);

endmodule

// File: rtl/acc_regs.sv
module acc_regs
   import acc_cpu_pkg::*;
#(
   parameter int                WORD_W   = 16,
   parameter int                ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] START_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_t              ctl,
   input  logic [WORD_W-1:0] mem_word,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] mar,
   output logic [WORD_W-1:0] mbr,
   output logic [WORD_W-1:0] ir,
   output logic [WORD_W-1:0] ac
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc  <= START_PC;
         mar <= '0;
         mbr <= '0;
         ir  <= '0;
         ac  <= '0;
      end else begin
         if (ctl.pc_inc)      pc  <= pc + ADDR_W'(1);
         if (ctl.mar_pc)      mar <= pc;
         else if (ctl.mar_ir) mar <= ir[ADDR_W-1:0];
         if (ctl.mbr_mem)     mbr <= mem_word;
         else if (ctl.mbr_ac) mbr <= ac;
         if (ctl.ir_ld)       ir  <= mbr;
         if (ctl.ac_ld)       ac  <= mbr;
         else if (ctl.ac_add) ac  <= ac + mbr;
      end
   end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int                WORD_W   = 16,
   parameter int                ADDR_W   = 12,
   parameter int                WORDS    = 4096,
   parameter logic [ADDR_W-1:0] START_PC = 12'h300
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pre_wr_en,
   input  logic [ADDR_W-1:0] pre_wr_addr,
   input  logic [WORD_W-1:0] pre_wr_data,
   output logic              halted,
   output logic [ADDR_W-1:0] dbg_pc,
   output logic [WORD_W-1:0] dbg_ac,
   output logic [WORD_W-1:0] dbg_ir
);

   localparam int OP_LSB = WORD_W - OP_W;

   if (OP_W + ADDR_W != WORD_W) begin : g_bad_split
      $error("opcode and address fields must fill the word exactly");
   end
   if (WORDS > (1 << ADDR_W) || WORDS < 1) begin : g_bad_depth
      $error("memory depth must fit the address field");
   end

   ctl_t              ctl;
   seq_state_e        st;
   logic [ADDR_W-1:0] mar;
   logic [WORD_W-1:0] mbr;
   logic [WORD_W-1:0] mem_word;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [WORD_W-1:0] mem_wdata;
   logic              core_we;

   assign core_we   = ctl.mem_wr;
   assign mem_we    = rst_n ? core_we : pre_wr_en;
   assign mem_addr  = rst_n ? mar     : pre_wr_addr;
   assign mem_wdata = rst_n ? mbr     : pre_wr_data;

   acc_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .mbr_op (mbr[WORD_W-1:OP_LSB]),
      .ir_op  (dbg_ir[WORD_W-1:OP_LSB]),
      .ctl    (ctl),
      .state  (st),
      .halted (halted)
   );

   acc_regs #(
      .WORD_W   (WORD_W),
      .ADDR_W   (ADDR_W),
      .START_PC (START_PC)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl      (ctl),
      .mem_word (mem_word),
      .pc       (dbg_pc),
      .mar      (mar),
      .mbr      (mbr),
      .ir       (dbg_ir),
      .ac       (dbg_ac)
   );

   acc_mem #(
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W),
      .WORDS  (WORDS)
   ) u_mem (
      .clk     (clk),
      .wr_en   (mem_we),
      .addr    (mem_addr),
      .wr_data (mem_wdata),
      .rd_word (mem_word)
   );

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
   import acc_cpu_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              halted,
   input logic [ADDR_W-1:0] pc,
   input logic [WORD_W-1:0] ac,
   input logic [WORD_W-1:0] ir,
   input seq_state_e        st,
   input logic              core_we,
   input logic [WORD_W-1:0] mbr
);

   p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pc != $past(pc)) |-> (pc == $past(pc) + ADDR_W'(1)));

   p_ac_only_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ac != $past(ac)) |-> ($past(st) == SQ_EXEC_WB));

   p_store_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
      core_we |-> (mbr == ac));

   p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   p_halt_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> ($stable(pc) && $stable(ac) && $stable(ir)));

   p_no_write_in_reset_r7: assert property (@(posedge clk)
      (!rst_n) |-> !core_we);

endmodule

bind acc_cpu_core acc_cpu_chk #(
   .WORD_W (WORD_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .halted  (halted),
   .pc      (dbg_pc),
   .ac      (dbg_ac),
   .ir      (dbg_ir),
   .st      (st),
   .core_we (core_we),
   .mbr     (mbr)
);

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb_top;

   localparam time CLK_PERIOD = 10ns;

   typedef struct {
      string       tag;
      logic [11:0] pc;
      logic [15:0] ac;
      logic [15:0] ir;
      int          cycles;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pre_wr_en = 1'b0;
   logic [11:0] pre_wr_addr = '0;
   logic [15:0] pre_wr_data = '0;
   logic        halted;
   logic [11:0] dbg_pc;
   logic [15:0] dbg_ac;
   logic [15:0] dbg_ir;

   int   n_checks = 0;
   int   n_errors = 0;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_cpu_core dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .pre_wr_en   (pre_wr_en),
      .pre_wr_addr (pre_wr_addr),
      .pre_wr_data (pre_wr_data),
      .halted      (halted),
      .dbg_pc      (dbg_pc),
      .dbg_ac      (dbg_ac),
      .dbg_ir      (dbg_ir)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL [%s] %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
   endtask

   task automatic poke(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk);
      pre_wr_en   = 1'b1;
      pre_wr_addr = a;
      pre_wr_data = d;
   endtask

   task automatic enter_reset();
      @(negedge clk);
      rst_n = 1'b0;
      pre_wr_en = 1'b0;
   endtask

   // driver: push the expected end state, then release the core
   task automatic launch(input string tag, input logic [11:0] pc, input logic [15:0] ac,
                         input logic [15:0] ir, input int cycles);
      exp_t e;
      e.tag = tag; e.pc = pc; e.ac = ac; e.ir = ir; e.cycles = cycles;
      sb_q.push_back(e);
      @(negedge clk);
      pre_wr_en = 1'b0;
      rst_n     = 1'b1;
   endtask

   // monitor: counts rising edges since release and compares at the halt
   initial begin
      int   cyc  = 0;
      bit   seen = 1'b0;
      exp_t e;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            cyc  = 0;
            seen = 1'b0;
         end else begin
            cyc++;
            if (halted && !seen) begin
               seen = 1'b1;
               if (sb_q.size() == 0) begin
                  check("R6", "unexpected halt", 32'd1, 32'd0);
               end else begin
                  e = sb_q.pop_front();
                  check("R8", {e.tag, " edges to halt"}, cyc, e.cycles);
                  check("R2", {e.tag, " final pc"}, {20'd0, dbg_pc}, {20'd0, e.pc});
                  check(e.tag, "final ac", {16'd0, dbg_ac}, {16'd0, e.ac});
                  check("R6", {e.tag, " halting word in ir"}, {16'd0, dbg_ir}, {16'd0, e.ir});
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_errors++;
      $display("FAIL [R8] watchdog: actual=running expected=halted");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state while preloading
      poke(12'h300, 16'h1940);
      poke(12'h301, 16'h5941);
      poke(12'h302, 16'h2941);
      poke(12'h303, 16'hF000);
      poke(12'h940, 16'h1234);
      poke(12'h941, 16'h0F0F);
      @(negedge clk);
      check("R1", "pc in reset", {20'd0, dbg_pc}, 32'h300);
      check("R1", "ac in reset", {16'd0, dbg_ac}, 32'h0);
      check("R1", "ir in reset", {16'd0, dbg_ir}, 32'h0);
      check("R1", "halted in reset", {31'd0, halted}, 32'h0);

      // run 1: load, add, store, halt; preload strobe held against 0x941 (R7)
      launch("R5", 12'h304, 16'h2143, 16'hF000, 20);
      pre_wr_en   = 1'b1;
      pre_wr_addr = 12'h941;
      pre_wr_data = 16'hDEAD;
      @(negedge clk);
      @(negedge clk);
      check("R2", "pc after fetch read", {20'd0, dbg_pc}, 32'h301);
      @(negedge clk);
      check("R2", "ir after decode", {16'd0, dbg_ir}, 32'h1940);
      wait (sb_q.size() == 0);
      repeat (8) @(negedge clk);
      check("R6", "pc frozen after halt", {20'd0, dbg_pc}, 32'h304);
      check("R6", "ac frozen after halt", {16'd0, dbg_ac}, 32'h2143);
      check("R6", "halted held", {31'd0, halted}, 32'h1);

      // run 2: read back stored word; opcode 0 halts
      enter_reset();
      poke(12'h300, 16'h1941);
      poke(12'h301, 16'h0000);
      @(negedge clk);
      check("R7", "halted cleared by reset", {31'd0, halted}, 32'h0);
      launch("R7", 12'h302, 16'h2143, 16'h0000, 9);
      wait (sb_q.size() == 0);
      @(negedge clk);
      check("R3", "loaded word from store", {16'd0, dbg_ac}, 32'h2143);

      // run 3: add wraps modulo 2^16
      enter_reset();
      poke(12'h300, 16'h1950);
      poke(12'h301, 16'h5951);
      poke(12'h302, 16'h7ABC);
      poke(12'h950, 16'hFFF0);
      poke(12'h951, 16'h0025);
      launch("R4", 12'h303, 16'h0015, 16'h7ABC, 15);
      wait (sb_q.size() == 0);
      @(negedge clk);
      check("R4", "sum with carry dropped", {16'd0, dbg_ac}, 32'h0015);

      summary();
      $finish;
   end

endmodule